// File: doc/BRIEF.md
# Carry-free signed-digit adder/subtractor

This block adds a plain binary word to, or subtracts it from, a signed-digit word of the same width and returns a signed-digit result. Each signed digit takes one of the values -1, 0 or +1 and travels as a pair of bits, one marking a positive digit and one marking a negative digit. Digit i carries the weight 2^i.

The sum is formed in two fixed steps per digit. The first step turns the operand digit and the binary bit into a transfer and an interim sum. The transfer can only be 0 or +1, and the interim sum can only be 0 or -1. The second step adds the interim sum of a digit to the transfer from the digit just below it. No transfer travels further than one position, so the delay is the same for every word length. For subtraction the digit polarities of the signed-digit operand are swapped before the first step, and those of the result are swapped after the second step.

The result has one digit more than the operands. An optional output register, chosen by a parameter, adds one cycle of latency. A digit with both bits set is not a valid digit. It counts as 0 and raises an error output.

Top module: `sd_addsub`

## Requirements
- R1: A digit is coded as (pos, neg): 00 is 0, 10 is +1, 01 is -1, and 11 is illegal. A word's value is the sum of digit_i * 2^i.
- R2: With add_i = 1, the value of the N+1 digit result equals value(a) + b, with b read as an unsigned integer.
- R3: With add_i = 0, the value of the result equals value(a) - b.
- R4: No result digit is ever coded 11.
- R5: An input digit coded 11 is treated as 0 and err_o is 1. err_o is 0 when every input digit is legal.
- R6: The top result digit is the transfer out of digit N-1. It is never -1 in add mode and never +1 in subtract mode.
- R7: With REG_OUT = 1, results and err_o appear one clock after the inputs. While rst_ni is low they read all zero. With REG_OUT = 0 the block is combinational.
- R8: An all-zero signed-digit operand with b = 0 gives an all-zero result in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| add_i | input | 1 | 1 = add b, 0 = subtract b |
| a_pos_i | input | N | Positive-digit bits of the signed-digit operand |
| a_neg_i | input | N | Negative-digit bits of the signed-digit operand |
| b_i | input | N | Unsigned binary operand |
| s_pos_o | output | N+1 | Positive-digit bits of the result |
| s_neg_o | output | N+1 | Negative-digit bits of the result |
| err_o | output | 1 | An input digit was coded 11 |

## Verification
The bench builds the block with N = 4 and REG_OUT = 1. That width makes it possible to run every legal signed-digit operand against every b in both modes, which is 2592 cases. The registered variant makes the one-cycle latency and the reset value observable. A second pass drives random bit pairs that include the illegal code, so that the zero substitution and err_o are exercised together with arithmetic checks.

// File: rtl/sd_pkg.sv
package sd_pkg;
  // digit code (pos,neg): 00 -> 0, 10 -> +1, 01 -> -1, 11 illegal
  typedef enum logic [1:0] {
    SD_ZERO = 2'b00,
    SD_NEG  = 2'b01,
    SD_POS  = 2'b10,
    SD_BAD  = 2'b11
  } sd_code_e;

  function automatic logic sd_illegal(input logic pos, input logic neg);
    return (sd_code_e'({pos, neg}) == SD_BAD);
  endfunction
endpackage

// File: rtl/sd_polarity.sv
module sd_polarity #(
  parameter int unsigned W = 8
) (
  input  logic         swap_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] neg_i,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] neg_o
);
  assign pos_o = swap_i ? neg_i : pos_i;
  assign neg_o = swap_i ? pos_i : neg_i;
endmodule

// File: rtl/sd_stage1_cell.sv
module sd_stage1_cell (
  input  logic pos_i,
  input  logic neg_i,
  input  logic b_i,
  output logic c_o,   // transfer, 0 or +1
  output logic z_o    // interim sum, 0 or -1 (1 means -1)
);
  logic is_zero;
  assign is_zero = ~pos_i & ~neg_i;
  assign c_o     = pos_i | (is_zero & b_i);
  assign z_o     = b_i ? is_zero : ~is_zero;
endmodule

// File: rtl/sd_stage2_cell.sv
module sd_stage2_cell (
  input  logic z_i,   // interim sum of this digit (-1 when set)
  input  logic c_i,   // transfer from the digit below (+1 when set)
  output logic s_pos_o,
  output logic s_neg_o
);
  assign s_pos_o = c_i & ~z_i;
  assign s_neg_o = z_i & ~c_i;
endmodule

// File: rtl/sd_addsub.sv
module sd_addsub
  import sd_pkg::*;
#(
  parameter int unsigned N       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         add_i,
  input  logic [N-1:0] a_pos_i,
  input  logic [N-1:0] a_neg_i,
  input  logic [N-1:0] b_i,
  output logic [N:0]   s_pos_o,
  output logic [N:0]   s_neg_o,
  output logic         err_o
);
  localparam int unsigned RW = N + 1;

  logic [N-1:0]  bad, ap_clean, an_clean, ap_sw, an_sw;
  logic [N-1:0]  c, z;
  logic [RW-1:0] sum_pos, sum_neg, res_pos, res_neg;
  logic          err_d;

  for (genvar i = 0; i < N; i++) begin : g_clean
    assign bad[i]      = sd_illegal(a_pos_i[i], a_neg_i[i]);
    assign ap_clean[i] = a_pos_i[i] & ~bad[i];
    assign an_clean[i] = a_neg_i[i] & ~bad[i];
  end
  assign err_d = |bad;

  sd_polarity #(.W(N)) u_swap_in (
    .swap_i(~add_i), .pos_i(ap_clean), .neg_i(an_clean),
    .pos_o(ap_sw), .neg_o(an_sw)
  );

  for (genvar i = 0; i < N; i++) begin : g_digit
    sd_stage1_cell u_s1 (
      .pos_i(ap_sw[i]), .neg_i(an_sw[i]), .b_i(b_i[i]),
      .c_o(c[i]), .z_o(z[i])
    );
    if (i == 0) begin : g_lsd
      sd_stage2_cell u_s2 (
        .z_i(z[i]), .c_i(1'b0),
        .s_pos_o(sum_pos[i]), .s_neg_o(sum_neg[i])
      );
    end else begin : g_mid
      sd_stage2_cell u_s2 (
        .z_i(z[i]), .c_i(c[i-1]),
        .s_pos_o(sum_pos[i]), .s_neg_o(sum_neg[i])
      );
    end
  end
  assign sum_pos[N] = c[N-1];
  assign sum_neg[N] = 1'b0;

  sd_polarity #(.W(RW)) u_swap_out (
    .swap_i(~add_i), .pos_i(sum_pos), .neg_i(sum_neg),
    .pos_o(res_pos), .neg_o(res_neg)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_pos_o <= '0;
        s_neg_o <= '0;
        err_o   <= 1'b0;
      end else begin
        s_pos_o <= res_pos;
        s_neg_o <= res_neg;
        err_o   <= err_d;
      end
    end

    AST_ERR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(a_pos_i & a_neg_i)) |=> err_o); // R5
    AST_OUT_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (s_pos_o == $past(res_pos)) && (s_neg_o == $past(res_neg))); // R7
  end else begin : g_comb
    assign s_pos_o = res_pos;
    assign s_neg_o = res_neg;
    assign err_o   = err_d;

    AST_ERR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(a_pos_i & a_neg_i)) |-> err_o); // R5
  end

  AST_RESULT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_pos & res_neg) == '0); // R4
  AST_TOP_ADD_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |-> !res_neg[N]); // R6
  AST_TOP_SUB_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add_i |-> !res_pos[N]); // R6
  AST_ZERO_IN_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_pos_i == '0 && a_neg_i == '0 && b_i == '0) |-> (res_pos == '0 && res_neg == '0)); // R8
endmodule

// File: tb/sd_addsub_tb_top.sv
module sd_addsub_tb_top;
  localparam int  N          = 4;
  localparam int  CLK_PERIOD = 10;
  localparam int  MAX_CYCLES = 200000;

  typedef struct {
    int  val;
    bit  err;
    bit  add;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         add;
  logic [N-1:0] a_pos, a_neg, b;
  logic [N:0]   s_pos, s_neg;
  logic         err;

  int n_checks = 0;
  int n_fail   = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_addsub #(.N(N), .REG_OUT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .add_i(add),
    .a_pos_i(a_pos), .a_neg_i(a_neg), .b_i(b),
    .s_pos_o(s_pos), .s_neg_o(s_neg), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: value of a digit word, illegal 11 counted as 0 (R5)
  function automatic int sd_value(input logic [N-1:0] p, input logic [N-1:0] m);
    int v = 0;
    for (int i = 0; i < N; i++)
      if (p[i] != m[i]) v += (p[i] ? 1 : -1) * (1 << i);
    return v;
  endfunction

  task automatic drive(input bit md, input logic [N-1:0] p, input logic [N-1:0] m,
                       input logic [N-1:0] bb, input string tag);
    exp_t e;
    @(negedge clk);
    add = md; a_pos = p; a_neg = m; b = bb;
    e.val = md ? sd_value(p, m) + int'(bb) : sd_value(p, m) - int'(bb);
    e.err = |(p & m);
    e.add = md;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: item driven at a negedge is registered at the next posedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        int v;
        e = q.pop_front();
        v = 0;
        for (int i = 0; i <= N; i++)
          if (s_pos[i] != s_neg[i]) v += (s_pos[i] ? 1 : -1) * (1 << i);
        check(v == e.val, e.tag, v, e.val);
        check((s_pos & s_neg) == '0, "R4 legal digits", int'(s_pos & s_neg), 0);
        check(err == e.err, "R5 err flag", int'(err), int'(e.err));
        check(e.add ? !s_neg[N] : !s_pos[N], "R6 top digit sign",
              int'({s_pos[N], s_neg[N]}), e.add ? 2 : 1);
      end
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYCLES, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    add = 1'b1; a_pos = '1; a_neg = '0; b = '1;
    repeat (3) @(posedge clk);
    #1;
    check(s_pos == '0 && s_neg == '0 && err == 1'b0, "R7 reset state",
          int'({s_pos, s_neg, err}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: zero in, zero out, both modes
    drive(1'b1, '0, '0, '0, "R8 zero add");
    drive(1'b0, '0, '0, '0, "R8 zero sub");
    // R2 directed: digits (-1,0,+1,-1) from MSD = -7, plus 6 gives -1
    drive(1'b1, 4'b0010, 4'b1001, 4'd6, "R2 directed -7+6");
    // R3 directed: -7 - 6 = -13
    drive(1'b0, 4'b0010, 4'b1001, 4'd6, "R3 directed -7-6");
    // R2/R3 extremes
    drive(1'b1, 4'b1111, 4'b0000, 4'd15, "R2 max+max");
    drive(1'b0, 4'b0000, 4'b1111, 4'd15, "R3 min-max");

    // R2/R3 exhaustive over legal digit words (R1 coding)
    for (int code = 0; code < 81; code++) begin
      logic [N-1:0] p, m;
      int t = code;
      for (int i = 0; i < N; i++) begin
        p[i] = (t % 3 == 1);
        m[i] = (t % 3 == 2);
        t = t / 3;
      end
      for (int bb = 0; bb < 16; bb++) begin
        drive(1'b1, p, m, 4'(bb), "R2 exhaustive add");
        drive(1'b0, p, m, 4'(bb), "R3 exhaustive sub");
      end
    end

    // R5: illegal codes treated as 0, directed then random
    drive(1'b1, 4'b1111, 4'b1111, 4'd5, "R5 all illegal add");
    drive(1'b0, 4'b1001, 4'b1100, 4'd3, "R5 mixed illegal sub");
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] p, m, bb;
      p  = 4'($urandom);
      m  = 4'($urandom);
      bb = 4'($urandom);
      drive(1'($urandom), p, m, bb, "R5 random with illegal");
    end

    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule